// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Divide Unit

This unit performs one multiply or one divide per request for an integer datapath. It uses a start/busy/done handshake. The caller presents a 32-bit destination word and a 16-bit source word. It selects the operation and chooses unsigned or two's-complement arithmetic, then pulses `start`.

A multiply takes only the low half of the destination. It returns the full 32-bit product one cycle later.

A divide treats the destination as a 32-bit dividend and the source as a 16-bit divisor. It runs a restoring shift-subtract loop that produces one quotient bit per cycle. The result is packed with the quotient in the low half and the remainder in the high half. Signed divides first divide the magnitudes, then correct the signs. The quotient truncates toward zero, and the remainder carries the sign of the dividend.

When the quotient cannot be represented in 16 bits, or when the divisor is zero, the write-enable stays low. In both cases the result port returns the original destination, so the register is left as it was.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, and before any request, `busy`, `done`, `wr_en` and `div_zero` are low.
- R2: `op_div`=0 selects multiply and `signed_mode`=1 selects two's-complement operands. A multiply returns `dst_in[15:0]` times `src_in` as a 32-bit product, and bits 31:16 of `dst_in` have no effect.
- R3: At the end of a multiply, N equals product bit 31, Z is set only for a zero product, and V and C are both low.
- R4: `op_div`=1 selects divide. When there is no overflow, result bits 15:0 hold the quotient and bits 31:16 hold the remainder. The quotient truncates toward zero, and a nonzero signed remainder has the sign of the dividend.
- R5: At the end of a divide without overflow, N equals quotient bit 15, Z is set only for a zero quotient, and V and C are low.
- R6: Overflow means an unsigned quotient above 65535, or a signed quotient outside -32768..32767. On overflow, V is high, C is low, `wr_en` is low and `result` equals the original `dst_in`. N and Z are then left unspecified.
- R7: A divide by zero completes one cycle after `start`. It raises `div_zero`, keeps `wr_en`, V and C low, and returns the original `dst_in` on `result`.
- R8: A multiply raises `done` one cycle after `start`. A divide by a nonzero divisor raises `done` 34 cycles after `start`, and `busy` is high in the cycles in between.
- R9: `done` is a single-cycle pulse, and `wr_en` is high only together with `done`. A `start`, or a change of operands, while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| signed_mode | input | 1 | 1 = two's-complement operands |
| dst_in | input | 32 | Destination word (multiplicand low half / dividend) |
| src_in | input | 16 | Source word (multiplier / divisor) |
| busy | output | 1 | Divide loop in progress |
| done | output | 1 | Result and flags valid this cycle |
| wr_en | output | 1 | Destination should be written with `result` |
| result | output | 32 | Packed result, or original destination when not written |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (always low) |
| div_zero | output | 1 | Divisor was zero |

## Verification
The hardest situations to reach are at the edges of the signed quotient range. A quotient of exactly -32768 is legal, while +32768 and the most negative dividend divided by -1 overflow. Only the sign-correction step separates these cases. The vector table places dividends on both sides of each limit, mixed with unsigned cases near 65535. The remaining hard case is a second request that arrives mid-loop. A directed sequence pulses `start` with different operands while `busy` is high, and then requires the first divide's result to appear at the normal cycle with no extra `done`.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_FIX  = 2'd2
    } mdstate_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/muldiv_mult.sv
module muldiv_mult #(
    parameter int HW = 16
) (
    input  logic              sgn,
    input  logic [HW-1:0]     a,
    input  logic [HW-1:0]     b,
    output logic [2*HW-1:0]   p
);
    localparam int FW = 2 * HW;

    logic [FW-1:0] a_ext;
    logic [FW-1:0] b_ext;

    // widen each operand by sign or zero so the low FW bits of the product
    // are correct for both modes
    always_comb begin
        a_ext = sgn ? {{HW{a[HW-1]}}, a} : {{HW{1'b0}}, a};
        b_ext = sgn ? {{HW{b[HW-1]}}, b} : {{HW{1'b0}}, b};
        p     = a_ext * b_ext;
    end
endmodule

// File: rtl/muldiv_divcore.sv
module muldiv_divcore #(
    parameter int NW = 32,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [NW-1:0] quo,
    output logic [DW-1:0] rem
);
    typedef struct packed {
        logic [NW-1:0] q;
        logic [DW-1:0] r;
        logic [DW-1:0] d;
    } dv_t;

    dv_t         dv_d, dv_q;
    logic [DW:0] trial;
    logic [DW:0] diff;

    always_comb begin
        dv_d  = dv_q;
        trial = {dv_q.r, dv_q.q[NW-1]};
        diff  = trial - {1'b0, dv_q.d};
        if (load) begin
            dv_d.q = num;
            dv_d.r = '0;
            dv_d.d = den;
        end else if (step) begin
            dv_d.r = diff[DW] ? trial[DW-1:0] : diff[DW-1:0];
            dv_d.q = {dv_q.q[NW-2:0], ~diff[DW]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign quo = dv_q.q;
    assign rem = dv_q.r;

    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (dv_q.r < dv_q.d));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
    parameter int HW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_div,
    input  logic              signed_mode,
    input  logic [2*HW-1:0]   dst_in,
    input  logic [HW-1:0]     src_in,
    output logic              busy,
    output logic              done,
    output logic              wr_en,
    output logic [2*HW-1:0]   result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              div_zero
);
    import muldiv_pkg::*;

    localparam int FW = 2 * HW;
    localparam int CW = $clog2(FW);
    localparam logic [FW-1:0] POS_LIM = {{(FW-HW+1){1'b0}}, {(HW-1){1'b1}}};
    localparam logic [FW-1:0] NEG_LIM = POS_LIM + 1'b1;

    typedef struct packed {
        mdstate_e      st;
        logic [CW-1:0] cnt;
        logic          sgn;
        logic          neg_q;
        logic          neg_r;
        logic [FW-1:0] dst;
        logic          done;
        logic          wr;
        logic          dz;
        logic [FW-1:0] res;
        ccr_t          f;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [FW-1:0] prod;
    logic [FW-1:0] num_mag;
    logic [HW-1:0] den_mag;
    logic [FW-1:0] quo;
    logic [HW-1:0] rem;
    logic          core_load;
    logic          core_step;
    logic          ovf;
    logic [FW-1:0] q_fix;
    logic [HW-1:0] r_fix;

    muldiv_mult #(.HW(HW)) u_mult (
        .sgn (signed_mode),
        .a   (dst_in[HW-1:0]),
        .b   (src_in),
        .p   (prod)
    );

    muldiv_divcore #(.NW(FW), .DW(HW)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (core_load),
        .step  (core_step),
        .num   (num_mag),
        .den   (den_mag),
        .quo   (quo),
        .rem   (rem)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.wr   = 1'b0;
        core_load = 1'b0;
        core_step = 1'b0;
        num_mag   = (signed_mode && dst_in[FW-1]) ? -dst_in : dst_in;
        den_mag   = (signed_mode && src_in[HW-1]) ? -src_in : src_in;
        if (ctl_q.sgn)
            ovf = ctl_q.neg_q ? (quo > NEG_LIM) : (quo > POS_LIM);
        else
            ovf = |quo[FW-1:HW];
        q_fix = ctl_q.neg_q ? -quo : quo;
        r_fix = ctl_q.neg_r ? -rem : rem;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.dst = dst_in;
                    ctl_d.dz  = 1'b0;
                    ctl_d.f   = '0;
                    if (!op_div) begin
                        ctl_d.res   = prod;
                        ctl_d.f.n   = prod[FW-1];
                        ctl_d.f.z   = (prod == '0);
                        ctl_d.wr    = 1'b1;
                        ctl_d.done  = 1'b1;
                    end else if (src_in == '0) begin
                        ctl_d.res  = dst_in;
                        ctl_d.dz   = 1'b1;
                        ctl_d.done = 1'b1;
                    end else begin
                        core_load   = 1'b1;
                        ctl_d.sgn   = signed_mode;
                        ctl_d.neg_r = signed_mode & dst_in[FW-1];
                        ctl_d.neg_q = signed_mode & (dst_in[FW-1] ^ src_in[HW-1]);
                        ctl_d.cnt   = '0;
                        ctl_d.st    = ST_LOOP;
                    end
                end
            end
            ST_LOOP: begin
                core_step = 1'b1;
                ctl_d.cnt = ctl_q.cnt + 1'b1;
                if (ctl_q.cnt == CW'(FW - 1)) ctl_d.st = ST_FIX;
            end
            ST_FIX: begin
                ctl_d.done = 1'b1;
                ctl_d.st   = ST_IDLE;
                if (ovf) begin
                    ctl_d.res = ctl_q.dst;
                    ctl_d.f.v = 1'b1;
                end else begin
                    ctl_d.res = {r_fix, q_fix[HW-1:0]};
                    ctl_d.f.n = q_fix[HW-1];
                    ctl_d.f.z = (q_fix[HW-1:0] == '0);
                    ctl_d.wr  = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy     = (ctl_q.st != ST_IDLE);
    assign done     = ctl_q.done;
    assign wr_en    = ctl_q.wr;
    assign result   = ctl_q.res;
    assign flag_n   = ctl_q.f.n;
    assign flag_z   = ctl_q.f.z;
    assign flag_v   = ctl_q.f.v;
    assign flag_c   = ctl_q.f.c;
    assign div_zero = ctl_q.dz;

    // R9
    wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);
    // R8
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R3
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flag_c);
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v) |-> (!wr_en && !div_zero));
    // R7
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (!wr_en && !flag_v && $past(!busy)));
endmodule

// File: tb/muldiv_unit_bench.sv
`timescale 1ns/1ps
module muldiv_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dst_in = '0;
    logic [15:0] src_in = '0;
    logic        busy, done, wr_en, flag_n, flag_z, flag_v, flag_c, div_zero;
    logic [31:0] result;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    muldiv_unit u_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .signed_mode(signed_mode), .dst_in(dst_in), .src_in(src_in),
        .busy(busy), .done(done), .wr_en(wr_en), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .div_zero(div_zero)
    );

    // {op_div, signed_mode, dst, src}
    localparam logic [49:0] VECS [0:16] = '{
        {1'b0, 1'b0, 32'h0000_00AA, 16'h0040},
        {1'b0, 1'b1, 32'h1234_FF56, 16'h0040},
        {1'b0, 1'b1, 32'hFFFF_0000, 16'h1234},
        {1'b0, 1'b1, 32'h0000_8000, 16'h8000},
        {1'b0, 1'b0, 32'hABCD_FFFF, 16'hFFFF},
        {1'b1, 1'b0, 32'h0001_8005, 16'h0040},
        {1'b1, 1'b1, 32'hFFFE_7FFB, 16'h0040},
        {1'b1, 1'b0, 32'h0010_0000, 16'h0001},
        {1'b1, 1'b1, 32'h8000_0000, 16'hFFFF},
        {1'b1, 1'b1, 32'hFFFF_8000, 16'h0001},
        {1'b1, 1'b1, 32'h0000_8000, 16'h0001},
        {1'b1, 1'b0, 32'h0000_0005, 16'h0007},
        {1'b1, 1'b1, 32'h0000_0064, 16'hFFF9},
        {1'b1, 1'b0, 32'hFFFE_FFFF, 16'hFFFF},
        {1'b1, 1'b0, 32'h0000_1234, 16'h0000},
        {1'b1, 1'b1, 32'hFFFF_FF00, 16'h0000},
        {1'b1, 1'b1, 32'hFFFF_FFF9, 16'h0002}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model(input logic op, input logic sgn, input logic [31:0] d,
                         input logic [15:0] s, output logic [31:0] res,
                         output logic wr, output logic n, output logic z,
                         output logic v, output logic dz, output int lat);
        longint a, b, p, qq, rr;
        res = d; wr = 0; n = 0; z = 0; v = 0; dz = 0; lat = 34;
        if (!op) begin
            if (sgn) begin a = $signed(d[15:0]); b = $signed(s); end
            else     begin a = d[15:0];          b = s;          end
            p = a * b;
            res = p[31:0]; wr = 1; n = res[31]; z = (res == 0); lat = 1;
        end else if (s == 0) begin
            dz = 1; lat = 1;
        end else begin
            if (sgn) begin a = $signed(d); b = $signed(s); end
            else     begin a = d;          b = s;          end
            qq = a / b;
            rr = a % b;
            if (sgn ? (qq > 32767 || qq < -32768) : (qq > 65535)) begin
                v = 1;
            end else begin
                res = {rr[15:0], qq[15:0]}; wr = 1; n = res[15]; z = (res[15:0] == 0);
            end
        end
    endtask

    task automatic run_op(input logic op, input logic sgn, input logic [31:0] d,
                          input logic [15:0] s, output int lat);
        @(negedge clk);
        start = 1; op_div = op; signed_mode = sgn; dst_in = d; src_in = s;
        @(negedge clk);
        start = 0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] e_res;
        logic e_wr, e_n, e_z, e_v, e_dz;
        int e_lat, lat;
        string rtag, ftag;

        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 wr_en", {31'b0, wr_en}, 32'd0);
        chk("R1 div_zero", {31'b0, div_zero}, 32'd0);

        for (int i = 0; i <= 16; i++) begin
            logic [49:0] vv;
            vv = VECS[i];
            model(vv[49], vv[48], vv[47:16], vv[15:0], e_res, e_wr, e_n, e_z, e_v, e_dz, e_lat);
            run_op(vv[49], vv[48], vv[47:16], vv[15:0], lat);
            rtag = !vv[49] ? "R2 product" : e_dz ? "R7 result" : e_v ? "R6 result" : "R4 result";
            ftag = !vv[49] ? "R3" : e_v ? "R6" : "R5";
            chk(rtag, result, e_res);
            chk(e_dz ? "R7 wr_en" : e_v ? "R6 wr_en" : "R4 wr_en", {31'b0, wr_en}, {31'b0, e_wr});
            chk({ftag, " V"}, {31'b0, flag_v}, {31'b0, e_v});
            chk({ftag, " C"}, {31'b0, flag_c}, 32'd0);
            chk("R7 div_zero", {31'b0, div_zero}, {31'b0, e_dz});
            if (!e_v && !e_dz) begin
                chk({ftag, " N"}, {31'b0, flag_n}, {31'b0, e_n});
                chk({ftag, " Z"}, {31'b0, flag_z}, {31'b0, e_z});
            end
            chk("R8 latency", lat, e_lat);
            @(negedge clk);
            // R9: done lasts one cycle
            chk("R9 done pulse", {31'b0, done}, 32'd0);
        end

        // R9: start and operand changes during a divide are ignored; R8 busy
        @(negedge clk);
        start = 1; op_div = 1; signed_mode = 0; dst_in = 32'h0001_8005; src_in = 16'h0040;
        @(negedge clk);
        start = 0;
        dst_in = 32'h7777_0003; src_in = 16'h0003; op_div = 0;
        chk("R8 busy", {31'b0, busy}, 32'd1);
        lat = 1;
        while (!done && lat < 200) begin
            start = (lat == 5);
            @(negedge clk);
            lat++;
        end
        start = 0;
        chk("R9 ignored start latency", lat, 34);
        chk("R9 ignored start result", result, 32'h0005_0600);
        @(negedge clk);
        chk("R9 no extra done", {31'b0, done}, 32'd0);
        chk("R9 idle after", {31'b0, busy}, 32'd0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule